// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block generates raster timing for an LCD panel. Software loads four configuration words over a write-strobe port while the block is idle: a mode word, a horizontal word, a vertical word and a clock/polarity word. It then starts the generator. The block divides the system clock into a pixel-clock enable. It walks each line through sync, leading wait, active pixels and trailing wait, and walks each frame through sync lines, leading blank lines, active lines and trailing blank lines.

Outputs are the pixel clock, line sync, frame sync, data-enable, an AC-bias toggle for passive panels and the pixel/line coordinates. In dual-panel passive mode the block reports a second line coordinate for the lower half, which is scanned in parallel with the upper half. A stop request lets the current frame finish. The generator then halts and raises a sticky completion flag.

Top module: `lcd_timing_gen`

## Requirements
- R1: Horizontal word (cfg_sel=1): [9:0] active pixels minus one, [15:10] sync width minus one, [23:16] trailing wait minus one, [31:24] leading wait minus one. A line lasts the sum of the four fields plus four pixel slots, in the order sync, leading wait, active, trailing wait.
- R2: Vertical word (cfg_sel=2): [9:0] active lines minus one, [15:10] sync lines, [31:24] leading blank lines, [23:16] trailing blank lines, all as plain counts. A frame lasts sync + leading + active + trailing lines. A phase with a count of zero is skipped.
- R3: Clock word (cfg_sel=3), bits [7:0] hold the divider D. pix_ce pulses once every 2*(D+1) clocks, or every D+1 clocks when bit 27 is set.
- R4: de is active only for active pixels of active lines. During that window px_x and px_y give the pixel and line index from 0; elsewhere they read 0.
- R5: Clock word bits 20, 21, 22 and 23 invert vsync, hsync, pclk and de respectively. Each output is active high when its bit is 0, including while idle.
- R6: Mode word (cfg_sel=0): bit 0 = 1 selects active mode, bit 1 = 1 selects dual panel. With clock word [15:8] = A, in passive mode acb toggles after every A+1 line ends. In active mode acb stays 0.
- R7: In passive dual mode px_y_lo equals px_y plus the active-line count during de. In any other mode it equals px_y.
- R8: A configuration write while running is ignored.
- R9: On stop, the current frame completes and running clears at the frame boundary, with done set. A stop present in the last cycle of a frame takes effect at that boundary.
- R10: done is sticky. It is cleared by sts_we with sts_wdata=1; sts_wdata=0 leaves it set.
- R11: After reset running, done, pix_ce, hsync, vsync and de are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Word select: 0 mode, 1 horizontal, 2 vertical, 3 clock |
| cfg_wdata | input | 32 | Configuration data |
| start | input | 1 | Start generation when idle |
| stop | input | 1 | Request halt at the end of the frame |
| sts_we | input | 1 | Status write strobe |
| sts_wdata | input | 1 | Writing 1 clears done |
| pix_ce | output | 1 | Pixel clock enable |
| pclk | output | 1 | Pixel clock pulse, polarity applied |
| hsync | output | 1 | Line sync |
| vsync | output | 1 | Frame sync |
| de | output | 1 | Data enable |
| acb | output | 1 | AC-bias toggle |
| px_x | output | 10 | Pixel index in the active line |
| px_y | output | 10 | Active line index |
| px_y_lo | output | 11 | Line index for the lower half in dual mode |
| running | output | 1 | Generator active |
| done | output | 1 | Sticky halt-complete flag |

## Verification
A stop request and the frame boundary can fall in the same cycle. The bench predicts the boundary from the configured timing. It drives stop exactly in the cycle of the last pixel enable of the first frame and checks that running falls and done rises at that edge. It then repeats the run with stop one cycle later and checks that the generator runs a whole further frame before it halts.

// File: rtl/lcd_timing_gen.sv
module lcd_timing_gen (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [1:0]  cfg_sel,
  input  logic [31:0] cfg_wdata,
  input  logic        start,
  input  logic        stop,
  input  logic        sts_we,
  input  logic        sts_wdata,
  output logic        pix_ce,
  output logic        pclk,
  output logic        hsync,
  output logic        vsync,
  output logic        de,
  output logic        acb,
  output logic [9:0]  px_x,
  output logic [9:0]  px_y,
  output logic [10:0] px_y_lo,
  output logic        running,
  output logic        done
);
  localparam logic [1:0] PH_SYNC = 2'd0, PH_LEAD = 2'd1, PH_ACT = 2'd2, PH_TRAIL = 2'd3;

  logic        ctl_active, ctl_dual, c_dpc, stopping, acb_q;
  logic [31:0] hcfg, vcfg;
  logic [7:0]  c_div, c_acb, acb_cnt;
  logic [3:0]  c_pol;
  logic [8:0]  div_cnt;
  logic [1:0]  h_st, v_st, v_nxt, v_first;
  logic [9:0]  h_cnt, h_lim;
  logic [10:0] v_cnt;
  logic        h_end, v_end, line_end, frame_end, de_act, dual_eff;

  wire [8:0] p_last = c_dpc ? {1'b0, c_div} : {c_div, 1'b1};

  function automatic logic [10:0] vlen(input logic [1:0] s);
    case (s)
      PH_SYNC: vlen = {5'd0, vcfg[15:10]};
      PH_LEAD: vlen = {3'd0, vcfg[31:24]};
      PH_ACT:  vlen = {1'b0, vcfg[9:0]} + 11'd1;
      default: vlen = {3'd0, vcfg[23:16]};
    endcase
  endfunction

  function automatic logic [1:0] vnext(input logic [1:0] s);
    logic [1:0] t;
    t = s + 2'd1;
    for (int i = 0; i < 3; i++)
      if (vlen(t) == 11'd0) t = t + 2'd1;
    return t;
  endfunction

  always_comb begin
    case (h_st)
      PH_SYNC: h_lim = {4'd0, hcfg[15:10]};
      PH_LEAD: h_lim = {2'd0, hcfg[31:24]};
      PH_ACT:  h_lim = hcfg[9:0];
      default: h_lim = {2'd0, hcfg[23:16]};
    endcase
  end

  assign v_nxt     = vnext(v_st);
  assign v_first   = vnext(PH_TRAIL);
  assign dual_eff  = ctl_dual & ~ctl_active;
  assign pix_ce    = running && (div_cnt == p_last);
  assign h_end     = (h_cnt == h_lim);
  assign v_end     = (v_cnt + 11'd1 == vlen(v_st));
  assign line_end  = pix_ce && (h_st == PH_TRAIL) && h_end;
  assign frame_end = line_end && v_end && (v_nxt <= v_st);
  assign de_act    = running && (h_st == PH_ACT) && (v_st == PH_ACT);

  assign vsync   = (running && v_st == PH_SYNC) ^ c_pol[0];
  assign hsync   = (running && h_st == PH_SYNC) ^ c_pol[1];
  assign pclk    = pix_ce ^ c_pol[2];
  assign de      = de_act ^ c_pol[3];
  assign acb     = acb_q;
  assign px_x    = de_act ? h_cnt : 10'd0;
  assign px_y    = de_act ? v_cnt[9:0] : 10'd0;
  assign px_y_lo = !de_act ? 11'd0 :
                   dual_eff ? v_cnt + {1'b0, vcfg[9:0]} + 11'd1 : v_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ctl_dual, ctl_active} <= 2'b00;
      hcfg <= '0; vcfg <= '0;
      c_div <= '0; c_acb <= '0; c_pol <= '0; c_dpc <= 1'b0;
      running <= 1'b0; stopping <= 1'b0; done <= 1'b0;
      div_cnt <= '0; h_st <= PH_SYNC; h_cnt <= '0; v_st <= PH_SYNC; v_cnt <= '0;
      acb_q <= 1'b0; acb_cnt <= '0;
    end else begin
      if (sts_we && sts_wdata) done <= 1'b0;
      if (!running) begin
        acb_q <= 1'b0;
        if (cfg_we) begin
          case (cfg_sel)
            2'd0: {ctl_dual, ctl_active} <= cfg_wdata[1:0];
            2'd1: hcfg <= cfg_wdata;
            2'd2: vcfg <= cfg_wdata;
            default: begin
              c_div <= cfg_wdata[7:0];
              c_acb <= cfg_wdata[15:8];
              c_pol <= cfg_wdata[23:20];
              c_dpc <= cfg_wdata[27];
            end
          endcase
        end
        if (start) begin
          running <= 1'b1; stopping <= 1'b0; div_cnt <= '0;
          h_st <= PH_SYNC; h_cnt <= '0; v_st <= v_first; v_cnt <= '0;
          acb_cnt <= '0;
        end
      end else begin
        if (stop) stopping <= 1'b1;
        div_cnt <= pix_ce ? 9'd0 : div_cnt + 9'd1;
        if (pix_ce) begin
          if (h_end) begin h_st <= h_st + 2'd1; h_cnt <= '0; end
          else h_cnt <= h_cnt + 10'd1;
          if (line_end) begin
            if (v_end) begin v_st <= v_nxt; v_cnt <= '0; end
            else v_cnt <= v_cnt + 11'd1;
            if (acb_cnt == c_acb) begin
              acb_cnt <= '0;
              if (!ctl_active) acb_q <= ~acb_q;
            end else acb_cnt <= acb_cnt + 8'd1;
            if (frame_end && (stopping || stop)) begin
              running <= 1'b0; done <= 1'b1;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/lcd_timing_gen_chk.sv
module lcd_timing_gen_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pix_ce,
  input logic        running,
  input logic        done,
  input logic        ctl_active,
  input logic        c_dpc,
  input logic [7:0]  c_div,
  input logic        acb,
  input logic        de_act,
  input logic [9:0]  px_x,
  input logic [31:0] hcfg,
  input logic [31:0] vcfg
);
  // R9
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(done) |-> $fell(running));
  // R9
  halt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) $fell(running) |-> done);
  // R8
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> ($stable(hcfg) && $stable(vcfg) && $stable(c_div)));
  // R3
  ce_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) (pix_ce && !c_dpc) |=> !pix_ce);
  // R3
  ce_run_chk: assert property (@(posedge clk) disable iff (!rst_n) pix_ce |-> running);
  // R4
  x_range_chk: assert property (@(posedge clk) disable iff (!rst_n) de_act |-> (px_x <= hcfg[9:0]));
  // R6
  acb_active_chk: assert property (@(posedge clk) disable iff (!rst_n) (running && ctl_active) |-> !acb);
endmodule

bind lcd_timing_gen lcd_timing_gen_chk u_chk (.*);

// File: tb/tb_lcd_timing_gen.sv
`timescale 1ns/1ps
module tb_lcd_timing_gen;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, start = 0, stop = 0, sts_we = 0, sts_wdata = 0;
  logic [1:0] cfg_sel = 0;
  logic [31:0] cfg_wdata = 0;
  logic pix_ce, pclk, hsync, vsync, de, acb, running, done;
  logic [9:0] px_x, px_y;
  logic [10:0] px_y_lo;
  int checks = 0, errors = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  lcd_timing_gen dut (.*);

  // {horizontal, vertical, clock, mode}
  localparam logic [127:0] VEC [4] = '{
    {32'h0200_0407, 32'h0201_0403, 32'h0000_0000, 32'h1},
    {32'h0001_0003, 32'h0000_0801, 32'h0000_0002, 32'h1},
    {32'h0102_0805, 32'h0103_0402, 32'h0800_0001, 32'h0},
    {32'h0000_0009, 32'h0000_0404, 32'h0800_0000, 32'h1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    @(negedge clk); cfg_we = 1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic load(input logic [127:0] v);
    wr(2'd0, v[31:0]); wr(2'd1, v[127:96]); wr(2'd2, v[95:64]); wr(2'd3, v[63:32]);
  endtask

  task automatic go();
    @(negedge clk); start = 1;
    @(negedge clk); start = 0;
  endtask

  task automatic halt();
    @(negedge clk); stop = 1;
    @(negedge clk); stop = 0;
    for (int g = 0; g < 20000 && running; g++) @(negedge clk);
  endtask

  task automatic clr_done();
    @(negedge clk); sts_we = 1; sts_wdata = 1;
    @(negedge clk); sts_we = 0; sts_wdata = 0;
  endtask

  task automatic measure(output int per, output int dec, output int pcc);
    logic pv;
    bit rise;
    pv = vsync; rise = 0;
    for (int g = 0; g < 20000 && !rise; g++) begin
      @(negedge clk); rise = vsync && !pv; pv = vsync;
    end
    per = 0; dec = 0; pcc = 0; rise = 0;
    while (!rise && per < 20000) begin
      dec += de; pcc += pix_ce;
      @(negedge clk); per++;
      rise = vsync && !pv; pv = vsync;
    end
  endtask

  function automatic int frame_clks(input logic [127:0] v);
    int line, lines, p;
    line  = v[111:106] + v[127:120] + v[105:96] + v[119:112] + 4;
    lines = v[79:74] + v[95:88] + v[73:64] + 1 + v[87:80];
    p     = v[59] ? v[39:32] + 1 : 2 * (v[39:32] + 1);
    return line * lines * p;
  endfunction

  initial begin
    #1_000_000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int per, dec, pcc, n, cnt;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R11 reset state
    chk(!running && !done && !pix_ce, "R11 flags", {running, done, pix_ce}, 0);
    chk(!hsync && !vsync && !de, "R11 syncs", {hsync, vsync, de}, 0);

    // R1 R2 R3 R4: timing table
    for (int i = 0; i < 4; i++) begin
      int p;
      load(VEC[i]);
      go();
      measure(per, dec, pcc);
      p = VEC[i][59] ? VEC[i][39:32] + 1 : 2 * (VEC[i][39:32] + 1);
      chk(per == frame_clks(VEC[i]), "R1 R2 frame period", per, frame_clks(VEC[i]));
      chk(pcc * p == per, "R3 pixel enables", pcc, per / p);
      chk(dec == (VEC[i][105:96] + 1) * (VEC[i][73:64] + 1) * p, "R4 de cycles",
          dec, (VEC[i][105:96] + 1) * (VEC[i][73:64] + 1) * p);
      halt();
      clr_done();
    end

    // R4 first active pixel coordinates
    load(VEC[0]); go();
    for (int g = 0; g < 5000 && !de; g++) @(negedge clk);
    chk(px_x == 0 && px_y == 0, "R4 first coord", {px_x, px_y}, 0);
    @(negedge clk); @(negedge clk);
    chk(px_x == 1, "R4 x advance", px_x, 1);

    // R8 write while running ignored
    wr(2'd1, 32'h0000_0001);
    measure(per, dec, pcc);
    chk(per == 224, "R8 ignored write", per, 224);
    halt(); clr_done();

    // R9 stop in the frame's last cycle
    n = 224;
    go();
    repeat (n - 1) @(negedge clk);
    stop = 1;
    @(negedge clk); stop = 0;
    chk(!running && done, "R9 stop at boundary", {running, done}, 2'b01);
    // R10 sticky clear
    @(negedge clk); sts_we = 1; sts_wdata = 0;
    @(negedge clk); sts_we = 0;
    chk(done, "R10 zero write keeps", done, 1);
    clr_done();
    chk(!done, "R10 one write clears", done, 0);

    // R9 stop one cycle late runs one more frame
    go();
    repeat (n) @(negedge clk);
    stop = 1;
    @(negedge clk); stop = 0;
    chk(running && !done, "R9 late stop continues", {running, done}, 2'b10);
    repeat (n - 2) @(negedge clk);
    chk(running, "R9 still running", running, 1);
    @(negedge clk);
    chk(!running && done, "R9 second boundary", {running, done}, 2'b01);
    clr_done();

    // R5 polarity inversion
    wr(2'd3, 32'h00F0_0000);
    @(negedge clk);
    chk(vsync && hsync && de && pclk, "R5 idle inverted", {vsync, hsync, de, pclk}, 4'hF);
    go();
    chk(!vsync && !hsync, "R5 active low", {vsync, hsync}, 0);
    halt(); clr_done();

    // R6 passive AC bias, A=1, line=28 clocks
    wr(2'd0, 32'h0); wr(2'd3, 32'h0000_0100);
    go();
    for (int g = 0; g < 5000 && !acb; g++) @(negedge clk);
    cnt = 0;
    while (acb && cnt < 5000) begin @(negedge clk); cnt++; end
    chk(cnt == 56, "R6 acb interval", cnt, 56);
    halt(); clr_done();
    // R6 active mode holds acb low
    wr(2'd0, 32'h1);
    go();
    cnt = 0;
    for (int g = 0; g < 600; g++) begin @(negedge clk); cnt += acb; end
    chk(cnt == 0, "R6 acb active low", cnt, 0);
    halt(); clr_done();

    // R7 dual passive lower line
    wr(2'd0, 32'h2);
    go();
    for (int g = 0; g < 5000 && !de; g++) @(negedge clk);
    repeat (60) @(negedge clk);
    for (int g = 0; g < 5000 && !de; g++) @(negedge clk);
    chk(de && px_y_lo == px_y + 4, "R7 dual lower", px_y_lo, px_y + 4);
    halt(); clr_done();
    wr(2'd0, 32'h3);
    go();
    for (int g = 0; g < 5000 && !de; g++) @(negedge clk);
    chk(de && px_y_lo == px_y, "R7 dual ignored active", px_y_lo, px_y);
    halt(); clr_done();

    finished = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule